// File: doc/BRIEF.md
# Double-Data-Rate Two-Beat Static RAM with Split Data Ports

This block is a synthesizable model of a small static RAM. It has one shared address bus, a write-data port and a separate read-data port. Commands are taken on the rising clock edge. Each command moves two words, one word per clock edge, so the data ports run at double data rate. A read is requested with an active-low read strobe and a write with an active-low write strobe. Every write beat carries its own active-low byte masks. Read and write commands may alternate on every cycle, and a sequence may start with either kind. The two-beat burst fills the cycle in which the other port receives its next command, so mixed traffic keeps both data ports busy.

Storage is organised as 2^(AW-1) lines of two W-bit words. A burst starting at word address A touches A and then A with bit 0 inverted, so the second access wraps inside the aligned pair. A read that follows a write to the same pair on the next cycle returns the new data. The read port has no back-pressure. A read result is offered exactly once, in two fixed half-cycle beats, and `q_valid` marks them. A consumer must take each beat in the half-cycle in which it is shown.

Top module: `ddr2b_sram`

## Requirements
- R1: While reset is low, and right after it is released, `q` is 0 and `q_valid` is 0. Reset clears every storage word to 0.
- R2: A read command (`rd_n` low at rising edge n, address A) shows word A on `q` while the clock is high after rising edge n+1. It shows word A^1 (bit 0 inverted) while the clock is low after the falling edge that follows.
- R3: `q_valid` is 1 for exactly the two half-cycles of each read burst and 0 at all other times.
- R4: In a cycle with no read burst, `q` keeps the last value it showed.
- R5: A write command (`wr_n` low and `rd_n` high at rising edge n, address A) stores the `d` value sampled at rising edge n+1 into word A. It stores the `d` value sampled at the following falling edge into word A^1.
- R6: Bit i of `bw_n` is sampled with each write beat. When it is 0, that beat writes bits 8i+7..8i. When it is 1, those bits keep their stored value.
- R7: When the burst starts at an odd address, the second word is A-1. Only address bit 0 changes within a burst.
- R8: A read issued on the cycle right after a write to the same aligned pair returns the newly written, byte-merged data.
- R9: When `rd_n` and `wr_n` are both low at the same rising edge, the read is performed and the write is dropped. Storage is left unchanged.
- R10: Commands that alternate write and read on every cycle deliver every read burst correctly, with no idle cycle between commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Commands are taken on the rising edge. Data uses both edges. |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address of the first beat of the burst |
| rd_n | input | 1 | Active-low read command |
| wr_n | input | 1 | Active-low write command |
| d | input | W | Write data, one beat per clock edge |
| bw_n | input | W/8 | Active-low byte masks for the current write beat |
| q | output | W | Read data, one beat per clock half |
| q_valid | output | 1 | High while `q` carries a read beat |

## Verification
A command register that holds a stale value shows up at the ports within two clock cycles. It appears as a burst whose `q_valid` is missing or extra, or as `q` moving when it should hold. A fault in the write staging stays hidden until that pair is read back. For that reason the stimulus reads each written pair, some on the very next cycle to exercise the forwarding path and some later to exercise the stored copy. Swapping the two halves or misrouting a byte mask shows up as a wrong word, or a wrong byte, within the same read burst.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

  // Which half of an aligned word pair an address selects.
  typedef enum logic [0:0] {
    HALF_EVEN = 1'b0,
    HALF_ODD  = 1'b1
  } half_e;

  function automatic half_e half_of(input logic bit0);
    return bit0 ? HALF_ODD : HALF_EVEN;
  endfunction

endpackage

// File: rtl/ddr2b_wr_capture.sv
// Write-beat staging: the first beat is taken on the rising edge after the command,
// the second on the falling edge that follows; both are committed on the next rise.
module ddr2b_wr_capture #(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_act,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [W-1:0]    d,
  input  logic [W/8-1:0]  bw_n,
  output logic            pend,
  output logic [AW-1:0]   pend_addr,
  output logic [W-1:0]    beat0,
  output logic [W/8-1:0]  mask0,
  output logic [W-1:0]    beat1,
  output logic [W/8-1:0]  mask1
);
  localparam int NB = W / 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      beat0     <= '0;
      mask0     <= {NB{1'b1}};
    end else begin
      pend <= cmd_act;
      if (cmd_act) begin
        pend_addr <= cmd_addr;
        beat0     <= d;
        mask0     <= bw_n;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat1 <= '0;
      mask1 <= {NB{1'b1}};
    end else if (pend) begin
      beat1 <= d;
      mask1 <= bw_n;
    end
  end

endmodule

// File: rtl/ddr2b_store.sv
// Pair-organised storage with byte-masked line commit and same-edge forwarding.
module ddr2b_store
  import ddr2b_pkg::*;
#(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [AW-1:0]   waddr,
  input  logic [W-1:0]    beat0,
  input  logic [W/8-1:0]  mask0,
  input  logic [W-1:0]    beat1,
  input  logic [W/8-1:0]  mask1,
  input  logic [AW-1:0]   raddr,
  output logic [W-1:0]    rword0,
  output logic [W-1:0]    rword1
);
  localparam int NB    = W / 8;
  localparam int LW    = 2 * W;
  localparam int IW    = AW - 1;
  localparam int LINES = 1 << IW;

  logic [LW-1:0] mem [LINES];

  logic [IW-1:0] wline, rline;
  half_e         wh, rh;
  logic [LW-1:0] cur, upd, sel;
  logic [W-1:0]  lo_d, hi_d;
  logic [NB-1:0] lo_m, hi_m;
  logic          hit;

  assign wline = waddr[AW-1:1];
  assign wh    = half_of(waddr[0]);
  assign cur   = mem[wline];

  // The first beat lands in the half the address names, the second in its partner.
  assign lo_d = (wh == HALF_EVEN) ? beat0 : beat1;
  assign lo_m = (wh == HALF_EVEN) ? mask0 : mask1;
  assign hi_d = (wh == HALF_EVEN) ? beat1 : beat0;
  assign hi_m = (wh == HALF_EVEN) ? mask1 : mask0;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign upd[g*8 +: 8]     = lo_m[g] ? cur[g*8 +: 8]     : lo_d[g*8 +: 8];
    assign upd[W+g*8 +: 8]   = hi_m[g] ? cur[W+g*8 +: 8]   : hi_d[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[wline] <= upd;
    end
  end

  assign rline = raddr[AW-1:1];
  assign rh    = half_of(raddr[0]);
  assign hit   = commit && (rline == wline);
  assign sel   = hit ? upd : mem[rline];

  always_comb begin
    if (rh == HALF_EVEN) begin
      rword0 = sel[W-1:0];
      rword1 = sel[LW-1:W];
    end else begin
      rword0 = sel[LW-1:W];
      rword1 = sel[W-1:0];
    end
  end

endmodule

// File: rtl/ddr2b_rd_ddr.sv
// Read output: the first word goes out on the rising edge, the second on the falling edge.
module ddr2b_rd_ddr #(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          r_act,
  input  logic [W-1:0]  word0,
  input  logic [W-1:0]  word1,
  output logic          v_rise,
  output logic [W-1:0]  q,
  output logic          q_valid
);
  logic [W-1:0] q_rise, q_fall, hold;
  logic         v_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rise <= '0;
      hold   <= '0;
      v_rise <= 1'b0;
    end else if (r_act) begin
      q_rise <= word0;
      hold   <= word1;
      v_rise <= 1'b1;
    end else begin
      q_rise <= q_fall;
      v_rise <= 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_fall <= '0;
      v_fall <= 1'b0;
    end else if (v_rise) begin
      q_fall <= hold;
      v_fall <= 1'b1;
    end else begin
      q_fall <= q_rise;
      v_fall <= 1'b0;
    end
  end

  assign q       = clk ? q_rise : q_fall;
  assign q_valid = clk ? v_rise : v_fall;

endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram #(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [W-1:0]   d,
  input  logic [W/8-1:0] bw_n,
  output logic [W-1:0]   q,
  output logic           q_valid
);
  localparam int NB = W / 8;

  logic          rd_q, wr_q;
  logic [AW-1:0] addr_q;
  logic          wr_pend, rd_vrise;
  logic [AW-1:0] wp_addr;
  logic [W-1:0]  wb0, wb1, rw0, rw1;
  logic [NB-1:0] wm0, wm1;

  // Command stage. A read wins over a write given in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= !rd_n;
      wr_q   <= !wr_n && rd_n;
      addr_q <= addr;
    end
  end

  ddr2b_wr_capture #(.AW(AW), .W(W)) u_wcap (
    .clk(clk), .rst_n(rst_n), .cmd_act(wr_q), .cmd_addr(addr_q),
    .d(d), .bw_n(bw_n), .pend(wr_pend), .pend_addr(wp_addr),
    .beat0(wb0), .mask0(wm0), .beat1(wb1), .mask1(wm1)
  );

  ddr2b_store #(.AW(AW), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(wr_pend), .waddr(wp_addr),
    .beat0(wb0), .mask0(wm0), .beat1(wb1), .mask1(wm1),
    .raddr(addr_q), .rword0(rw0), .rword1(rw1)
  );

  ddr2b_rd_ddr #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .r_act(rd_q), .word0(rw0), .word1(rw1),
    .v_rise(rd_vrise), .q(q), .q_valid(q_valid)
  );

endmodule

// File: rtl/ddr2b_sram_chk.sv
module ddr2b_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic wr_n,
  input logic wpend,
  input logic vrise
);
  // Read command leads to a valid first beat two rising edges later (R2)
  p_rd_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> ##1 vrise);
  // No read command, no burst (R3)
  p_no_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> ##1 !vrise);
  // A lone write command reaches the commit stage (R5)
  p_wr_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && rd_n) |=> ##1 wpend);
  // Without a write command nothing is committed (R5)
  p_wr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> ##1 !wpend);
  // Colliding commands drop the write (R9)
  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !rd_n) |=> ##1 !wpend);
endmodule

bind ddr2b_sram ddr2b_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
  .wpend(wr_pend), .vrise(rd_vrise)
);

// File: tb/ddr2b_sram_test.sv
module ddr2b_sram_test;
  localparam int AW = 6;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [W-1:0]  d = '0;
  logic [1:0]    bw_n = 2'b11;
  logic [W-1:0]  q;
  logic          q_valid;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ddr2b_sram #(.AW(AW), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .d(d), .bw_n(bw_n), .q(q), .q_valid(q_valid)
  );

  typedef struct packed {
    logic        rdn;
    logic        wrn;
    logic [5:0]  a;
    logic [15:0] d0;
    logic [1:0]  m0;
    logic [15:0] d1;
    logic [1:0]  m1;
    logic        va;
    logic [15:0] qa;
    logic        vb;
    logic [15:0] qb;
  } vec_t;

  // Each row: command at this rising edge, write beats for the previous command,
  // expected q/q_valid in the high and low halves that follow.
  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,6'd4,  16'h0000,2'b11,16'h0000,2'b11, 1'b0,16'h0000,1'b0,16'h0000}, // W4
    '{1'b0,1'b1,6'd8,  16'h1111,2'b00,16'h2222,2'b00, 1'b0,16'h0000,1'b0,16'h0000}, // R8, data for W4 (R5)
    '{1'b1,1'b0,6'd9,  16'h0000,2'b11,16'h0000,2'b11, 1'b1,16'h0000,1'b1,16'h0000}, // W9, R8 zero (R1)
    '{1'b0,1'b1,6'd4,  16'hAAAA,2'b00,16'hBBBB,2'b00, 1'b0,16'h0000,1'b0,16'h0000}, // R4, data W9
    '{1'b0,1'b1,6'd9,  16'h0000,2'b11,16'h0000,2'b11, 1'b1,16'h1111,1'b1,16'h2222}, // R2 order
    '{1'b1,1'b1,6'd0,  16'h0000,2'b11,16'h0000,2'b11, 1'b1,16'hAAAA,1'b1,16'hBBBB}, // R7 odd start
    '{1'b1,1'b1,6'd0,  16'h0000,2'b11,16'h0000,2'b11, 1'b0,16'hBBBB,1'b0,16'hBBBB}, // R4 hold
    '{1'b1,1'b0,6'd5,  16'h0000,2'b11,16'h0000,2'b11, 1'b0,16'hBBBB,1'b0,16'hBBBB}, // W5
    '{1'b0,1'b1,6'd5,  16'h3333,2'b10,16'h4444,2'b01, 1'b0,16'hBBBB,1'b0,16'hBBBB}, // R5 next cycle, masks (R6)
    '{1'b1,1'b0,6'd12, 16'h0000,2'b11,16'h0000,2'b11, 1'b1,16'h2233,1'b1,16'h4411}, // R8 forward + R6
    '{1'b0,1'b1,6'd13, 16'h5555,2'b00,16'h6666,2'b00, 1'b0,16'h4411,1'b0,16'h4411}, // R13 after W12
    '{1'b1,1'b1,6'd0,  16'h0000,2'b11,16'h0000,2'b11, 1'b1,16'h6666,1'b1,16'h5555}, // R8 odd partner
    '{1'b1,1'b0,6'd20, 16'h0000,2'b11,16'h0000,2'b11, 1'b0,16'h5555,1'b0,16'h5555}, // W20
    '{1'b0,1'b1,6'd20, 16'h7777,2'b00,16'h8888,2'b00, 1'b0,16'h5555,1'b0,16'h5555}, // R20
    '{1'b0,1'b0,6'd8,  16'h0000,2'b11,16'h0000,2'b11, 1'b1,16'h7777,1'b1,16'h8888}, // collide (R9)
    '{1'b1,1'b1,6'd0,  16'hFFFF,2'b00,16'hFFFF,2'b00, 1'b1,16'hBBBB,1'b1,16'hAAAA}, // read won (R9)
    '{1'b0,1'b1,6'd8,  16'h0000,2'b11,16'h0000,2'b11, 1'b0,16'hAAAA,1'b0,16'hAAAA}, // reread 8
    '{1'b1,1'b1,6'd0,  16'h0000,2'b11,16'h0000,2'b11, 1'b1,16'hBBBB,1'b1,16'hAAAA}  // write dropped (R9)
  };

  logic [W-1:0] sqa, sqb;
  logic         sva, svb;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called with the clock low; returns with the clock low one cycle later.
  task automatic step(input logic rdn, input logic wrn, input logic [AW-1:0] a,
                      input logic [W-1:0] d0, input logic [1:0] m0,
                      input logic [W-1:0] d1, input logic [1:0] m1);
    rd_n = rdn; wr_n = wrn; addr = a; d = d0; bw_n = m0;
    @(posedge clk); #5;
    sqa = q; sva = q_valid;
    d = d1; bw_n = m1;
    @(negedge clk); #5;
    sqb = q; svb = q_valid;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R1 q in reset", q, 16'h0000);
    chk("R1 q_valid in reset", {15'd0, q_valid}, 16'h0000);
    rst_n = 1'b1;
    step(1'b1, 1'b1, '0, '0, 2'b11, '0, 2'b11);
    chk("R1 q after reset", sqa, 16'h0000);
    chk("R1 q_valid after reset", {15'd0, sva | svb}, 16'h0000);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].rdn, TBL[i].wrn, TBL[i].a, TBL[i].d0, TBL[i].m0, TBL[i].d1, TBL[i].m1);
      chk($sformatf("R3 row %0d valid hi", i), {15'd0, sva}, {15'd0, TBL[i].va});
      chk($sformatf("R2/R4 row %0d q hi", i), sqa, TBL[i].qa);
      chk($sformatf("R3 row %0d valid lo", i), {15'd0, svb}, {15'd0, TBL[i].vb});
      chk($sformatf("R2/R4 row %0d q lo", i), sqb, TBL[i].qb);
    end

    // Reset mid-run clears outputs and storage (R1)
    rst_n = 1'b0;
    #1;
    chk("R1 q on mid reset", q, 16'h0000);
    chk("R1 q_valid on mid reset", {15'd0, q_valid}, 16'h0000);
    @(negedge clk); #5;
    rst_n = 1'b1;
    step(1'b0, 1'b1, 6'd4, '0, 2'b11, '0, 2'b11);
    step(1'b1, 1'b1, '0, '0, 2'b11, '0, 2'b11);
    chk("R1 storage cleared hi", sqa, 16'h0000);
    chk("R1 storage cleared lo", sqb, 16'h0000);
    chk("R1 read valid after reset", {15'd0, sva & svb}, 16'h0001);

    // Continuous write/read alternation (R10)
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0, 6'(32 + 2*i), '0, 2'b11, '0, 2'b11);
      if (i > 0) begin
        chk("R10 first beat", sqa, 16'h1000 + 16'(i-1));
        chk("R10 second beat", sqb, 16'h2000 + 16'(i-1));
        chk("R10 valid", {15'd0, sva & svb}, 16'h0001);
      end
      step(1'b0, 1'b1, 6'(32 + 2*i), 16'h1000 + 16'(i), 2'b00, 16'h2000 + 16'(i), 2'b00);
    end
    step(1'b1, 1'b1, '0, '0, 2'b11, '0, 2'b11);
    chk("R10 last first beat", sqa, 16'h1007);
    chk("R10 last second beat", sqb, 16'h2007);
    // Stored copy, not forwarded, of an earlier pair (R10)
    step(1'b0, 1'b1, 6'd35, '0, 2'b11, '0, 2'b11);
    step(1'b1, 1'b1, '0, '0, 2'b11, '0, 2'b11);
    chk("R10 stored odd hi", sqa, 16'h2001);
    chk("R10 stored odd lo", sqb, 16'h1001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule